// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Splitter

This block sits between a processor whose bus time-shares its low address bits with data and the memory or peripheral side of a system. At the start of each bus cycle the processor raises an address-strobe signal while the shared lines carry address. The block passes that address straight through while the strobe is high. It holds the address once the strobe drops, so the memory side sees a stable 20-bit address for the rest of the cycle. It latches the active-low high-byte enable in the same way.

During the data phase, a transceiver section moves data between the shared processor lines and a separate memory-side data bus. An active-low data-enable gates the transfer, and a direction signal steers it. The shared lines are modelled as separate input, output and output-enable ports, so the pads can be placed outside the block.

The parameter `DATA_W` picks the variant. With 16, address bits 15..0 share the processor lines with data and bits 19..16 arrive on dedicated lines. With 8, only bits 7..0 are shared, bits 19..8 arrive on dedicated lines, and the high byte lane is never used.

Top module: `bdm_bus_demux`

## Requirements
- R1: While `rst` is high, `addr_o` is 0, `bhe_n_o` is 1, `mem_oe_o` and `proc_oe_o` are 0, and both data outputs are 0.
- R2: While `ale_i` is high, `addr_o` equals `{ahi_i, ad_i}` in the same cycle, with `ad_i` forming the low bits.
- R3: While `ale_i` is low, `addr_o` and `bhe_n_o` keep the values present at the last rising clock edge at which `ale_i` was high, whatever the shared and upper lines do.
- R4: The address is split as follows. With `DATA_W`=16, `addr_o[15:0]` comes from `ad_i` and `addr_o[19:16]` from `ahi_i`. With `DATA_W`=8, `addr_o[7:0]` comes from `ad_i` and `addr_o[19:8]` from `ahi_i`.
- R5: With `DATA_W`=16, `bhe_n_o` is latched from `bhe_n_i` together with the address. With `DATA_W`=8, `bhe_n_o` is always 1.
- R6: While `den_n_i` is 1, `mem_oe_o` and `proc_oe_o` are 0, and `mem_dout_o` and `proc_dout_o` are 0.
- R7: While `den_n_i` is 0 and `dt_r_i` is 1 (toward memory), `mem_oe_o` is 1, `mem_dout_o` equals `ad_i`, and `proc_oe_o` is 0.
- R8: While `den_n_i` is 0 and `dt_r_i` is 0 (toward processor), `proc_oe_o` is 1, `proc_dout_o` equals `mem_din_i`, and `mem_oe_o` is 0.
- R9: `lane_en_o` (bit 0 = low byte, bit 1 = high byte) is 0 while `den_n_i` is 1. With `den_n_i` at 0, the value depends on the variant. With `DATA_W`=16, bit 0 is `!addr_o[0]` and bit 1 is `!bhe_n_o`. With `DATA_W`=8, it is 2'b01.
- R10: `mem_oe_o` and `proc_oe_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ad_i | input | DATA_W | Shared address/data lines as seen from the processor |
| ahi_i | input | 20-DATA_W | Dedicated upper address lines |
| ale_i | input | 1 | Address strobe, high during the address phase |
| bhe_n_i | input | 1 | Active-low high-byte enable from the processor |
| den_n_i | input | 1 | Active-low data transfer enable |
| dt_r_i | input | 1 | Direction: 1 toward memory, 0 toward processor |
| mem_din_i | input | DATA_W | Data from the memory side |
| addr_o | output | 20 | Demultiplexed address |
| bhe_n_o | output | 1 | Latched active-low high-byte enable |
| lane_en_o | output | 2 | Valid byte lanes for the current transfer |
| mem_dout_o | output | DATA_W | Data driven toward memory |
| mem_oe_o | output | 1 | Output enable for the memory-side data bus |
| proc_dout_o | output | DATA_W | Data driven back onto the shared lines |
| proc_oe_o | output | 1 | Output enable for the shared lines |

## Verification
Several behaviours are checked by assertions on every cycle:
- The reset values of the outputs.
- The same-cycle pass-through while the strobe is high.
- That the address stays stable across consecutive strobe-low cycles.
- That both drivers are released while the transfer enable is inactive.
- That the two output enables never overlap.
- That the narrow variant never enables the high byte lane.

Other behaviours can only be shown by the bench's scenarios, run on both variants side by side:
- That the held value is the one captured at the last strobe edge, even when the lines change.
- The exact bit split between shared and dedicated lines.
- That data passes correctly in each direction.
- The byte-lane decode for even and odd addresses.

// File: rtl/bdm_pkg.sv
package bdm_pkg;

    localparam int ADDR_W = 20;

    typedef enum logic {
        DIR_TO_PROC = 1'b0,
        DIR_TO_MEM  = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              bhe_n;
    } addr_phase_t;

    localparam addr_phase_t PHASE_RESET = '{addr: '0, bhe_n: 1'b1};

    function automatic logic [1:0] lanes_for(input logic wide,
                                             input logic active,
                                             input logic a0,
                                             input logic bhe_n);
        logic [1:0] l;
        if (!active)   l = 2'b00;
        else if (wide) l = {~bhe_n, ~a0};
        else           l = 2'b01;
        return l;
    endfunction

endpackage

// File: rtl/bdm_addr_latch.sv
module bdm_addr_latch
    import bdm_pkg::*;
#(
    parameter int SHARE_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ale,
    input  logic [SHARE_W-1:0]        ad_i,
    input  logic [ADDR_W-SHARE_W-1:0] ahi_i,
    input  logic                      bhe_n_i,
    output addr_phase_t               phase_o
);
    localparam logic WIDE = (SHARE_W > 8);

    addr_phase_t live;
    addr_phase_t held;

    always_comb begin
        live.addr  = {ahi_i, ad_i};
        live.bhe_n = WIDE ? bhe_n_i : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)      held <= PHASE_RESET;
        else if (ale) held <= live;
    end

    always_comb begin
        if (rst)      phase_o = PHASE_RESET;
        else if (ale) phase_o = live;
        else          phase_o = held;
    end

    logic [ADDR_W-1:0] addr_w;
    logic              bhe_w;
    assign addr_w = phase_o.addr;
    assign bhe_w  = phase_o.bhe_n;

    // R2
    a_r2_follow_strobe: assert property (@(posedge clk) disable iff (rst)
        ale |-> (addr_w == {ahi_i, ad_i}));

    // R3
    a_r3_hold_addr: assert property (@(posedge clk) disable iff (rst)
        (!ale && $past(!ale)) |-> ($stable(addr_w) && $stable(bhe_w)));

endmodule

// File: rtl/bdm_xcvr.sv
module bdm_xcvr
    import bdm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         den_n,
    input  xfer_dir_e    dir,
    input  logic [W-1:0] from_proc,
    input  logic [W-1:0] from_mem,
    output logic [W-1:0] to_mem,
    output logic         mem_oe,
    output logic [W-1:0] to_proc,
    output logic         proc_oe
);
    logic active;
    assign active = !rst && !den_n;

    always_comb begin
        mem_oe  = active && (dir == DIR_TO_MEM);
        proc_oe = active && (dir == DIR_TO_PROC);
        to_mem  = mem_oe  ? from_proc : '0;
        to_proc = proc_oe ? from_mem  : '0;
    end

    // R10
    a_r10_oe_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_oe && proc_oe));

    // R6
    a_r6_release: assert property (@(posedge clk) disable iff (rst)
        den_n |-> (!mem_oe && !proc_oe && to_mem == '0 && to_proc == '0));

endmodule

// File: rtl/bdm_lane_decode.sv
module bdm_lane_decode
    import bdm_pkg::*;
#(
    parameter bit WIDE = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic       a0,
    input  logic       bhe_n,
    output logic [1:0] lane_en
);
    assign lane_en = lanes_for(WIDE, active, a0, bhe_n);

    generate
        if (!WIDE) begin : g_narrow
            // R9
            a_r9_no_high_lane: assert property (@(posedge clk) disable iff (rst)
                !lane_en[1]);
        end
    endgenerate

endmodule

// File: rtl/bdm_bus_demux.sv
module bdm_bus_demux
    import bdm_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [DATA_W-1:0]        ad_i,
    input  logic [ADDR_W-DATA_W-1:0] ahi_i,
    input  logic                     ale_i,
    input  logic                     bhe_n_i,
    input  logic                     den_n_i,
    input  logic                     dt_r_i,
    input  logic [DATA_W-1:0]        mem_din_i,
    output logic [ADDR_W-1:0]        addr_o,
    output logic                     bhe_n_o,
    output logic [1:0]               lane_en_o,
    output logic [DATA_W-1:0]        mem_dout_o,
    output logic                     mem_oe_o,
    output logic [DATA_W-1:0]        proc_dout_o,
    output logic                     proc_oe_o
);
    localparam bit WIDE = (DATA_W == 16);

    generate
        if (DATA_W != 8 && DATA_W != 16) begin : g_bad_width
            initial $error("DATA_W must be 8 or 16");
        end
    endgenerate

    addr_phase_t phase;
    xfer_dir_e   dir;
    assign dir = xfer_dir_e'(dt_r_i);

    bdm_addr_latch #(.SHARE_W(DATA_W)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .ale     (ale_i),
        .ad_i    (ad_i),
        .ahi_i   (ahi_i),
        .bhe_n_i (bhe_n_i),
        .phase_o (phase)
    );

    bdm_xcvr #(.W(DATA_W)) u_xcvr (
        .clk       (clk),
        .rst       (rst),
        .den_n     (den_n_i),
        .dir       (dir),
        .from_proc (ad_i),
        .from_mem  (mem_din_i),
        .to_mem    (mem_dout_o),
        .mem_oe    (mem_oe_o),
        .to_proc   (proc_dout_o),
        .proc_oe   (proc_oe_o)
    );

    bdm_lane_decode #(.WIDE(WIDE)) u_lanes (
        .clk     (clk),
        .rst     (rst),
        .active  (!rst && !den_n_i),
        .a0      (phase.addr[0]),
        .bhe_n   (phase.bhe_n),
        .lane_en (lane_en_o)
    );

    assign addr_o  = phase.addr;
    assign bhe_n_o = phase.bhe_n;

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |-> (addr_o == '0 && bhe_n_o && !mem_oe_o && !proc_oe_o));

    generate
        if (!WIDE) begin : g_narrow_bhe
            // R5
            a_r5_bhe_inactive: assert property (@(posedge clk) disable iff (rst)
                bhe_n_o);
        end
    endgenerate

endmodule

// File: tb/bdm_bus_demux_tb.sv
module bdm_bus_demux_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic ale, bhe_n_in, den_n, dt_r;

    // 16-bit variant
    logic [15:0] ad16, md16, mout16, pout16;
    logic [3:0]  ahi16;
    logic [19:0] addr16;
    logic        bhe16, moe16, poe16;
    logic [1:0]  lane16;

    // 8-bit variant
    logic [7:0]  ad8, md8, mout8, pout8;
    logic [11:0] ahi8;
    logic [19:0] addr8;
    logic        bhe8, moe8, poe8;
    logic [1:0]  lane8;

    bdm_bus_demux #(.DATA_W(16)) u_dut (
        .clk(clk), .rst(rst), .ad_i(ad16), .ahi_i(ahi16), .ale_i(ale),
        .bhe_n_i(bhe_n_in), .den_n_i(den_n), .dt_r_i(dt_r), .mem_din_i(md16),
        .addr_o(addr16), .bhe_n_o(bhe16), .lane_en_o(lane16),
        .mem_dout_o(mout16), .mem_oe_o(moe16), .proc_dout_o(pout16), .proc_oe_o(poe16)
    );

    bdm_bus_demux #(.DATA_W(8)) u_dut_b8 (
        .clk(clk), .rst(rst), .ad_i(ad8), .ahi_i(ahi8), .ale_i(ale),
        .bhe_n_i(bhe_n_in), .den_n_i(den_n), .dt_r_i(dt_r), .mem_din_i(md8),
        .addr_o(addr8), .bhe_n_o(bhe8), .lane_en_o(lane8),
        .mem_dout_o(mout8), .mem_oe_o(moe8), .proc_dout_o(pout8), .proc_oe_o(poe8)
    );

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] exp_lanes(input logic wide, input logic en,
                                             input logic [19:0] a, input logic bn);
        if (!en) return 2'b00;
        if (wide) return {~bn, ~a[0]};
        return 2'b01;
    endfunction

    task automatic idle_lines();
        ale = 0; den_n = 1; dt_r = 0; bhe_n_in = 1;
        ad16 = '0; ahi16 = '0; md16 = '0; ad8 = '0; ahi8 = '0; md8 = '0;
    endtask

    // One bus cycle on both variants: address phase, data phase, release
    task automatic bus_cycle(input logic [19:0] a, input logic bn, input logic to_mem,
                             input logic [15:0] pdat, input logic [15:0] mdat);
        logic [1:0] l16, l8;
        @(negedge clk);
        ale = 1; den_n = 1; bhe_n_in = bn;
        ad16 = a[15:0]; ahi16 = a[19:16];
        ad8  = a[7:0];  ahi8  = a[19:8];
        #1;
        chk("R2 follow16", addr16, a);
        chk("R2 follow8",  addr8,  a);
        chk("R6 idle oe16", {moe16, poe16, mout16, pout16}, 0);
        chk("R6 idle oe8",  {moe8, poe8, mout8, pout8}, 0);
        chk("R9 idle lanes", {lane16, lane8}, 0);
        @(negedge clk);
        // data phase: shared and upper lines now carry unrelated values
        ale = 0; bhe_n_in = ~bn;
        ad16 = pdat; ahi16 = ~a[19:16];
        ad8  = pdat[7:0]; ahi8 = ~a[19:8];
        md16 = mdat; md8 = mdat[7:0];
        den_n = 0; dt_r = to_mem;
        #1;
        chk("R3 R4 hold16", addr16, a);
        chk("R3 R4 hold8",  addr8,  a);
        chk("R5 bhe16", bhe16, bn);
        chk("R5 bhe8",  bhe8,  1'b1);
        l16 = exp_lanes(1'b1, 1'b1, a, bn);
        l8  = exp_lanes(1'b0, 1'b1, a, bn);
        chk("R9 lanes16", lane16, l16);
        chk("R9 lanes8",  lane8,  l8);
        chk("R10 exclusive", (moe16 & poe16) | (moe8 & poe8), 0);
        if (to_mem) begin
            chk("R7 dir16", {moe16, poe16, mout16}, {1'b1, 1'b0, pdat});
            chk("R7 dir8",  {moe8, poe8, mout8},    {1'b1, 1'b0, pdat[7:0]});
        end else begin
            chk("R8 dir16", {poe16, moe16, pout16}, {1'b1, 1'b0, mdat});
            chk("R8 dir8",  {poe8, moe8, pout8},    {1'b1, 1'b0, mdat[7:0]});
        end
        @(negedge clk);
        den_n = 1;
        #1;
        chk("R6 release16", {moe16, poe16, mout16, pout16}, 0);
        chk("R6 release8",  {moe8, poe8, mout8, pout8}, 0);
        chk("R3 still held", addr16, a);
    endtask

    initial begin
        void'($urandom(32'd4711));
        idle_lines();
        rst = 1;
        repeat (3) @(negedge clk);
        ale = 1; ad16 = 16'hBEEF; ahi16 = 4'hA; ad8 = 8'hEF; ahi8 = 12'hABE; den_n = 0; dt_r = 1;
        #1;
        chk("R1 reset addr16", addr16, 0);
        chk("R1 reset addr8",  addr8,  0);
        chk("R1 reset bhe",    {bhe16, bhe8}, 2'b11);
        chk("R1 reset oe",     {moe16, poe16, moe8, poe8, mout16, mout8}, 0);
        @(negedge clk);
        idle_lines();
        rst = 0;

        // directed corners
        bus_cycle(20'h00000, 1'b0, 1'b1, 16'h1234, 16'hAAAA);
        bus_cycle(20'hFFFFF, 1'b1, 1'b0, 16'h5678, 16'h5A5A);
        bus_cycle(20'h12345, 1'b0, 1'b0, 16'hFFFF, 16'h0001);
        bus_cycle(20'h8ACE0, 1'b1, 1'b1, 16'h0000, 16'hFFFF);

        // random cycles
        for (int i = 0; i < 60; i++) begin
            bus_cycle($urandom() & 20'hFFFFF, $urandom() & 1, $urandom() & 1,
                      $urandom() & 16'hFFFF, $urandom() & 16'hFFFF);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(CLK_PERIOD * 200000);
                fails++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule